// File: doc/BRIEF.md
# Programmable Interrupt Source Router

The router takes a wide vector of peripheral interrupt request lines and folds them onto a smaller set of central interrupt channels. Every source has its own map register that names the channel it drives. When several sources name the same channel, that channel is pending while any one of them is asserted, so the sources share it.

Each central channel then passes through an enable bit and a type bit. A disabled channel is dropped. An enabled channel is steered either to the fast request output or to the normal request output. For each of the two outputs, the block also reports the lowest-numbered active channel, which is the highest-priority one. A simple register port writes and reads the map, enable and type registers. The request and index outputs are registered: they follow the sources and settings one clock later.

Top module: `irq_router`

## Requirements
- R1: After reset, every channel enable bit is 0, every type bit is 0 (normal), and map register i holds i modulo 32. Both request outputs are low and both index outputs hold the none code 32.
- R2: A write with `reg_we` high to address i (0 to 47) stores `reg_wdata[4:0]` in map register i. `reg_rdata` returns the stored value zero-extended, one clock after the address is presented.
- R3: A channel is pending while any source whose map register names it is asserted, so several sources can share one channel.
- R4: A channel whose enable bit is 0 drives neither request output nor index output, whatever its sources do. The enable register is at address 0x40, and bit c of it is channel c.
- R5: The type register is at address 0x41. An enabled pending channel whose type bit is 1 goes to the fast path (`fiq_req`, `fiq_idx`). One whose type bit is 0 goes to the normal path (`irq_req`, `irq_idx`), never to both.
- R6: `fiq_req` is the OR of the enabled, pending, fast-typed channels. `irq_req` is the same OR over the normal-typed channels.
- R7: Each index output gives the lowest-numbered active channel of its type, or 32 when that type has none.
- R8: Writes to addresses other than 0 to 47, 0x40 and 0x41 change nothing, and reads of them return 0.
- R9: A change on `src_irq` shows on the request and index outputs exactly one clock edge later, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_irq | input | 48 | Peripheral interrupt request lines, active high, level |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| fiq_req | output | 1 | Fast interrupt request |
| irq_req | output | 1 | Normal interrupt request |
| fiq_idx | output | 6 | Highest-priority active fast channel, 32 when none |
| irq_idx | output | 6 | Highest-priority active normal channel, 32 when none |

## Verification
The assertions assume that sources are level signals held steady around the rising clock edge. They also assume that the register port is driven only with known values outside reset, because the checker compares the registered outputs against the channel state of the previous cycle.

The bench changes `src_irq`, `reg_we`, `reg_addr` and `reg_wdata` only on falling edges. It samples results on a later falling edge, after the one or two rising edges the write and output registers need, so every observed value comes from a settled cycle.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  // Register layout: map registers occupy addresses 0 .. N_SRC-1
  localparam int unsigned ADDR_W   = 7;
  localparam int unsigned DATA_W   = 32;
  localparam logic [ADDR_W-1:0] EN_ADDR  = 7'h40;
  localparam logic [ADDR_W-1:0] TYP_ADDR = 7'h41;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_MAP,
    SEL_EN,
    SEL_TYP
  } reg_sel_e;
endpackage

// File: rtl/irq_map_regs.sv
module irq_map_regs
  import irq_router_pkg::*;
#(
  parameter int unsigned N_SRC = 48,
  parameter int unsigned N_CH  = 32,
  parameter int unsigned CH_W  = $clog2(N_CH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_we,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [DATA_W-1:0]       reg_wdata,
  output logic [DATA_W-1:0]       reg_rdata,
  output logic [N_SRC*CH_W-1:0]   map_flat,
  output logic [N_CH-1:0]         chan_en,
  output logic [N_CH-1:0]         chan_fiq
);
  localparam int unsigned SRC_IW = $clog2(N_SRC);

  logic [CH_W-1:0]   map_q [N_SRC];
  logic [CH_W-1:0]   map_d [N_SRC];
  logic [N_CH-1:0]   en_q, en_d, typ_q, typ_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  reg_sel_e          sel;
  logic [SRC_IW-1:0] src_sel;

  assign src_sel = reg_addr[SRC_IW-1:0];

  always_comb begin
    if (reg_addr < ADDR_W'(N_SRC))  sel = SEL_MAP;
    else if (reg_addr == EN_ADDR)   sel = SEL_EN;
    else if (reg_addr == TYP_ADDR)  sel = SEL_TYP;
    else                            sel = SEL_NONE;
  end

  // next state
  always_comb begin
    map_d = map_q;
    en_d  = en_q;
    typ_d = typ_q;
    if (reg_we) begin
      unique case (sel)
        SEL_MAP:  map_d[src_sel] = reg_wdata[CH_W-1:0];
        SEL_EN:   en_d  = reg_wdata[N_CH-1:0];
        SEL_TYP:  typ_d = reg_wdata[N_CH-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    unique case (sel)
      SEL_MAP:  rdata_d = DATA_W'(map_q[src_sel]);
      SEL_EN:   rdata_d = DATA_W'(en_q);
      SEL_TYP:  rdata_d = DATA_W'(typ_q);
      default:  rdata_d = '0;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(N_SRC); i++) map_q[i] <= CH_W'(i % N_CH);
      en_q    <= '0;
      typ_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (reg_we) begin
        map_q <= map_d;
        en_q  <= en_d;
        typ_q <= typ_d;
      end
      rdata_q <= rdata_d;
    end
  end

  for (genvar s = 0; s < N_SRC; s++) begin : g_flat
    assign map_flat[s*CH_W +: CH_W] = map_q[s];
  end

  assign chan_en   = en_q;
  assign chan_fiq  = typ_q;
  assign reg_rdata = rdata_q;
endmodule

// File: rtl/irq_src_combine.sv
module irq_src_combine #(
  parameter int unsigned N_SRC = 48,
  parameter int unsigned N_CH  = 32,
  parameter int unsigned CH_W  = $clog2(N_CH)
) (
  input  logic [N_SRC-1:0]      src,
  input  logic [N_SRC*CH_W-1:0] map_flat,
  output logic [N_CH-1:0]       pend
);
  // one OR tree per channel over all sources that select it
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int s = 0; s < int'(N_SRC); s++) begin
        if (src[s] && (map_flat[s*CH_W +: CH_W] == CH_W'(c))) hit = 1'b1;
      end
    end
    assign pend[c] = hit;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N     = 32,
  parameter int unsigned IDX_W = $clog2(N) + 1
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  // lowest set bit wins; N is the empty code
  always_comb begin
    idx = IDX_W'(N);
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
  assign any = |vec;
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned N_SRC = 48,
  parameter int unsigned N_CH  = 32,
  localparam int unsigned CH_W  = $clog2(N_CH),
  localparam int unsigned IDX_W = CH_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_irq,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              fiq_req,
  output logic              irq_req,
  output logic [IDX_W-1:0]  fiq_idx,
  output logic [IDX_W-1:0]  irq_idx
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [N_SRC*CH_W-1:0] map_flat_w;
  logic [N_CH-1:0]       chan_en_w, chan_fiq_w, pend_w;
  logic [N_CH-1:0]       fiq_act, irq_act;
  logic                  fiq_any, irq_any;
  logic [IDX_W-1:0]      fiq_idx_d, irq_idx_d;

  irq_map_regs #(.N_SRC(N_SRC), .N_CH(N_CH), .CH_W(CH_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .map_flat  (map_flat_w),
    .chan_en   (chan_en_w),
    .chan_fiq  (chan_fiq_w)
  );

  irq_src_combine #(.N_SRC(N_SRC), .N_CH(N_CH), .CH_W(CH_W)) u_comb (
    .src      (src_irq),
    .map_flat (map_flat_w),
    .pend     (pend_w)
  );

  assign fiq_act = pend_w & chan_en_w &  chan_fiq_w;
  assign irq_act = pend_w & chan_en_w & ~chan_fiq_w;

  irq_prio_enc #(.N(N_CH), .IDX_W(IDX_W)) u_enc_fiq (
    .vec (fiq_act), .any (fiq_any), .idx (fiq_idx_d)
  );

  irq_prio_enc #(.N(N_CH), .IDX_W(IDX_W)) u_enc_irq (
    .vec (irq_act), .any (irq_any), .idx (irq_idx_d)
  );

  logic             fiq_q, irq_q;
  logic [IDX_W-1:0] fiq_idx_q, irq_idx_q;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      fiq_q     <= 1'b0;
      irq_q     <= 1'b0;
      fiq_idx_q <= IDX_W'(N_CH);
      irq_idx_q <= IDX_W'(N_CH);
    end else begin
      fiq_q     <= fiq_any;
      irq_q     <= irq_any;
      fiq_idx_q <= fiq_idx_d;
      irq_idx_q <= irq_idx_d;
    end
  end

  assign fiq_req = fiq_q;
  assign irq_req = irq_q;
  assign fiq_idx = fiq_idx_q;
  assign irq_idx = irq_idx_q;
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int unsigned N_CH  = 32,
  parameter int unsigned IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fiq_req,
  input logic             irq_req,
  input logic [IDX_W-1:0] fiq_idx,
  input logic [IDX_W-1:0] irq_idx,
  input logic [N_CH-1:0]  pend,
  input logic [N_CH-1:0]  en,
  input logic [N_CH-1:0]  typ
);
  localparam int unsigned CH_W = IDX_W - 1;

  logic [N_CH-1:0] fiq_seen_q, irq_seen_q, en_seen_q;
  logic [N_CH-1:0] fiq_below, irq_below;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fiq_seen_q <= '0;
      irq_seen_q <= '0;
      en_seen_q  <= '0;
    end else begin
      fiq_seen_q <= pend & en & typ;
      irq_seen_q <= pend & en & ~typ;
      en_seen_q  <= en;
    end
  end

  assign fiq_below = (N_CH'(1) << fiq_idx[CH_W-1:0]) - N_CH'(1);
  assign irq_below = (N_CH'(1) << irq_idx[CH_W-1:0]) - N_CH'(1);

  assert_fiq_any_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_req == (|fiq_seen_q));
  assert_irq_any_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == (|irq_seen_q));
  assert_fiq_none_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !fiq_req |-> fiq_idx == IDX_W'(N_CH));
  assert_irq_none_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> irq_idx == IDX_W'(N_CH));
  assert_fiq_prio_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_req |-> (fiq_idx < IDX_W'(N_CH)) && fiq_seen_q[fiq_idx[CH_W-1:0]]
                && ((fiq_seen_q & fiq_below) == '0));
  assert_irq_prio_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_idx < IDX_W'(N_CH)) && irq_seen_q[irq_idx[CH_W-1:0]]
                && ((irq_seen_q & irq_below) == '0));
  assert_split_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_req && irq_req) |-> fiq_idx != irq_idx);
  assert_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_seen_q == '0) |-> !fiq_req && !irq_req);
endmodule

bind irq_router irq_router_chk #(.N_CH(N_CH), .IDX_W(IDX_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .fiq_req (fiq_req),
  .irq_req (irq_req),
  .fiq_idx (fiq_idx),
  .irq_idx (irq_idx),
  .pend    (pend_w),
  .en      (chan_en_w),
  .typ     (chan_fiq_w)
);

// File: tb/irq_router_bench.sv
module irq_router_bench;
  localparam int NS = 48;
  localparam int NC = 32;
  localparam logic [6:0] A_EN  = 7'h40;
  localparam logic [6:0] A_TYP = 7'h41;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [47:0] src_irq;
  logic        reg_we;
  logic [6:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        fiq_req, irq_req;
  logic [5:0]  fiq_idx, irq_idx;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [4:0]  m_map [NS];
  logic [31:0] m_en, m_typ;

  always #5 clk = ~clk;

  irq_router u_irq_router (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fiq_req(fiq_req), .irq_req(irq_req), .fiq_idx(fiq_idx), .irq_idx(irq_idx)
  );

  task automatic cmp(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a < 7'(NS)) m_map[a] = d[4:0];
    else if (a == A_EN)  m_en  = d;
    else if (a == A_TYP) m_typ = d;
  endtask

  task automatic rd_check(string req, logic [6:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    cmp(req, reg_rdata, exp);
  endtask

  task automatic settle();
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  // expected outputs from the model registers and the current sources
  task automatic expect_out(string req);
    logic [31:0] pend, fa, ia;
    logic [5:0]  fi, ii;
    pend = '0;
    for (int s = 0; s < NS; s++) if (src_irq[s]) pend[m_map[s]] = 1'b1;
    fa = pend & m_en & m_typ;
    ia = pend & m_en & ~m_typ;
    fi = 6'd32; ii = 6'd32;
    for (int c = NC - 1; c >= 0; c--) begin
      if (fa[c]) fi = 6'(c);
      if (ia[c]) ii = 6'(c);
    end
    cmp({req, " fiq_req"}, 32'(fiq_req), 32'(|fa));
    cmp({req, " irq_req"}, 32'(irq_req), 32'(|ia));
    cmp({req, " fiq_idx"}, 32'(fiq_idx), 32'(fi));
    cmp({req, " irq_idx"}, 32'(irq_idx), 32'(ii));
  endtask

  task automatic t_reset();
    expect_out("R1");
    cmp("R1 fiq_idx none", 32'(fiq_idx), 32);
    rd_check("R1 map5", 7'd5, 32'd5);
    rd_check("R1 map40", 7'd40, 32'd8);
    rd_check("R1 enable", A_EN, 32'd0);
    rd_check("R1 type", A_TYP, 32'd0);
  endtask

  task automatic t_regs();
    wr(7'd3, 32'd17);
    rd_check("R2 map3", 7'd3, 32'd17);
    wr(7'd47, 32'hFFFF_FFE3);
    rd_check("R2 map47 low bits", 7'd47, 32'd3);
    wr(7'd47, 32'd15);
    wr(7'd3, 32'd3);
  endtask

  task automatic t_masked();
    @(negedge clk); src_irq = '1;
    settle();
    expect_out("R4");
    cmp("R4 irq_req masked", 32'(irq_req), 0);
    @(negedge clk); src_irq = '0;
  endtask

  task automatic t_basic();
    wr(A_EN, 32'hFFFF_FFFF);
    @(negedge clk); src_irq = 48'h80;
    settle();
    cmp("R6 irq_req", 32'(irq_req), 1);
    cmp("R7 irq_idx", 32'(irq_idx), 7);
    cmp("R5 fiq quiet", 32'(fiq_req), 0);
  endtask

  task automatic t_share();
    wr(7'd40, 32'd2);
    wr(7'd10, 32'd2);
    @(negedge clk); src_irq = 48'h0;
    src_irq[40] = 1'b1;
    settle();
    cmp("R3 share via 40", 32'(irq_idx), 2);
    @(negedge clk); src_irq = 48'h0; src_irq[10] = 1'b1;
    settle();
    cmp("R3 share via 10", 32'(irq_idx), 2);
    @(negedge clk); src_irq[40] = 1'b1;
    settle();
    expect_out("R3 both");
  endtask

  task automatic t_type();
    wr(A_TYP, 32'h0000_0004);
    settle();
    cmp("R5 fiq_idx", 32'(fiq_idx), 2);
    cmp("R5 irq none", 32'(irq_idx), 32);
    cmp("R5 irq_req low", 32'(irq_req), 0);
    wr(A_EN, 32'hFFFF_FFFB);
    settle();
    cmp("R4 disabled fiq", 32'(fiq_req), 0);
    wr(A_EN, 32'hFFFF_FFFF);
  endtask

  task automatic t_unmapped();
    wr(7'h50, 32'h0);
    wr(7'h3F, 32'h0);
    rd_check("R8 read unmapped", 7'h50, 32'd0);
    rd_check("R8 enable kept", A_EN, 32'hFFFF_FFFF);
    rd_check("R8 type kept", A_TYP, 32'h4);
    settle();
    expect_out("R8");
  endtask

  task automatic t_latency();
    @(negedge clk); src_irq = '0;
    settle();
    @(negedge clk); src_irq = 48'h1_0000;
    #1;
    cmp("R9 not yet", 32'(irq_req), 0);
    @(posedge clk); @(negedge clk);
    cmp("R9 one edge", 32'(irq_req), 1);
    cmp("R9 idx", 32'(irq_idx), 16);
  endtask

  task automatic t_random();
    for (int k = 0; k < 60; k++) begin
      if (k % 6 == 0) wr(7'($urandom_range(0, NS - 1)), $urandom);
      if (k % 10 == 3) wr(A_EN, $urandom);
      if (k % 10 == 7) wr(A_TYP, $urandom);
      @(negedge clk);
      src_irq = {$urandom, $urandom} & {16'($urandom), 32'($urandom)};
      settle();
      expect_out("R7 random");
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src_irq = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    for (int i = 0; i < NS; i++) m_map[i] = 5'(i % NC);
    m_en = '0; m_typ = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_masked();
    t_basic();
    t_share();
    t_type();
    t_unmapped();
    t_latency();
    t_random();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule